// File: doc/BRIEF.md
# Watchdog Timer with Timed Configuration Unlock

This block is a watchdog timer for a small processor subsystem. Software reaches it through two byte-wide registers: a control register that holds the time-out select, the enable, a change-enable indicator and an interrupt-enable bit, and a status register that holds the watchdog-reset flag. A watchdog-reset instruction input (`kick`) restarts the time-out counter. When the counter reaches the selected period while the watchdog is enabled, the block raises either a one-cycle reset request or a one-cycle interrupt.

The enable bit and the period select are guarded. Software first writes the control register with the change-enable and enable bits both set. This opens a short window. Within that window a second write, with change-enable cleared, commits the new period and enable. Any direct write outside this sequence leaves both fields untouched. A safety input (`lockMode`) keeps the watchdog permanently enabled. A pending watchdog-reset flag also keeps it enabled until software clears the flag.

The period select picks one of `NUM_TAPS` counter lengths, from 2^MIN_EXP to 2^(MIN_EXP+NUM_TAPS-1) clock cycles. Codes beyond the last tap select the longest length.

Top module: `wdog_timed_lock`

## Requirements
- R1: After reset, the control register reads 0x00 when `lockMode` is low. The status register reads 0x00, and `rstReq` and `irq` are low.
- R2: While `lockMode` is high, control bit 4 (enable) reads 1 whatever software writes, and the watchdog counts.
- R3: A control write (`regSel`=0) with bit 5 clear and no window open leaves bits [3:0] (period select) and bit 4 (stored enable) unchanged.
- R4: A control write with bits 5 and 4 both set opens the change window, and control bit 5 then reads 1. A write with bit 5 set but bit 4 clear opens nothing.
- R5: A control write with bit 5 clear, made while the window is open, loads bits [3:0] and bit 4 from the written data and closes the window at once.
- R6: If no commit write arrives, the window closes by itself. A commit is accepted on any of the four clock edges that follow the opening write and is ignored after them.
- R7: In lock mode, the enable value carried by the commit write is ignored. Its period select is still loaded.
- R8: While enabled and with bit 6 clear, `rstReq` goes high for exactly one cycle, 2^(MIN_EXP+sel) cycles after the edge that sampled `kick`. The status flag (bit 0) is set in the same cycle.
- R9: A `kick` restarts the count, so no time-out occurs at the point the earlier count would have reached.
- R10: Period codes at or above `NUM_TAPS` select the longest length, 2^(MIN_EXP+NUM_TAPS-1).
- R11: Writing the status register (`regSel`=1) with bit 0 clear clears the flag. Writing it with bit 0 set has no effect. While the flag is set, control bit 4 reads 1.
- R12: Control bit 6 (interrupt enable) is written directly by any control write. While it is set, a time-out pulses `irq` for one cycle instead of `rstReq` and leaves the flag unchanged.
- R13: While the watchdog is disabled, no time-out occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rstN | input | 1 | Active-low synchronous reset |
| lockMode | input | 1 | Safety lock: enable is forced on |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 = control register, 1 = status register |
| regWrData | input | 8 | Write data |
| kick | input | 1 | Watchdog-reset instruction: restarts the count |
| ctrlRdData | output | 8 | Control read: [3:0] period, 4 enable, 5 change window, 6 interrupt enable |
| statRdData | output | 8 | Status read: bit 0 watchdog-reset flag |
| rstReq | output | 1 | One-cycle system reset request |
| irq | output | 1 | One-cycle time-out interrupt |

## Verification
A register write shows up on the read ports in the cycle right after the edge that took it. A commit is accepted when zero to three idle edges separate it from the opening write. `rstReq` or `irq` rises exactly 2^(MIN_EXP+sel) cycles after the edge that sampled `kick` and falls one cycle later.

The scoreboard's driver records the cycle number of each edge it drives. From that number it queues items due at exact future cycles: one cycle before the pulse, the pulse cycle itself, and one cycle after. The monitor compares each item in the cycle it falls due, sampling between clock edges. The bench uses small prescaler parameters, so that every tap, including the reserved codes, can be timed to the cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int SEL_W    = 4;
  localparam int DATA_W   = 8;
  localparam int BIT_EN   = 4;
  localparam int BIT_CHG  = 5;
  localparam int BIT_IRQ  = 6;
  localparam int BIT_FLAG = 0;

  // Strobes from the control side to the counter datapath
  typedef struct packed {
    logic             run;      // watchdog effectively enabled
    logic             restart;  // watchdog-reset instruction
    logic [SEL_W-1:0] tapSel;   // raw period select code
  } wdStrobe_t;
endpackage

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int MIN_EXP  = 11,
  parameter int NUM_TAPS = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  wdStrobe_t strobe,
  output logic      expire
);
  localparam int CW = MIN_EXP + NUM_TAPS - 1;
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_TAPS - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] tapLim [NUM_TAPS];
  logic [CW-1:0] limSel;
  logic [SEL_W-1:0] tapIdx;

  // terminal count of each prescaler tap
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign tapLim[g] = CW'((64'd1 << (MIN_EXP + g)) - 64'd1);
  end

  // reserved codes fold onto the longest tap
  assign tapIdx = (strobe.tapSel > LAST_SEL) ? LAST_SEL : strobe.tapSel;

  always_comb begin
    limSel = tapLim[NUM_TAPS-1];
    for (int i = 0; i < NUM_TAPS; i++) begin
      if (tapIdx == SEL_W'(i)) limSel = tapLim[i];
    end
  end

  assign expire = strobe.run && !strobe.restart && (cnt >= limSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!strobe.run || strobe.restart || expire) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int WIN_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lockMode,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              kick,
  input  logic              expire,
  output wdStrobe_t         strobe,
  output logic [DATA_W-1:0] ctrlRdData,
  output logic [DATA_W-1:0] statRdData,
  output logic              rstReq,
  output logic              irq
);
  localparam int WW = $clog2(WIN_CYC + 1);

  logic [SEL_W-1:0] perSel;
  logic             enBit;
  logic             intEn;
  logic             flag;
  logic [WW-1:0]    winLeft;
  logic             winOpen;
  logic             enEff;
  logic             ctrlWr;
  logic             statWr;
  logic             openWr;
  logic             commitWr;
  logic             unusedBits;

  assign winOpen  = (winLeft != '0);
  assign enEff    = enBit | lockMode | flag;
  assign ctrlWr   = regWrEn && !regSel;
  assign statWr   = regWrEn && regSel;
  assign openWr   = ctrlWr && regWrData[BIT_CHG] && regWrData[BIT_EN];
  assign commitWr = ctrlWr && !regWrData[BIT_CHG] && winOpen;
  assign unusedBits = regWrData[DATA_W-1];

  // change window countdown
  always_ff @(posedge clk) begin
    if (!rstN) begin
      winLeft <= '0;
    end else if (openWr) begin
      winLeft <= WW'(WIN_CYC);
    end else if (commitWr) begin
      winLeft <= '0;
    end else if (winOpen) begin
      winLeft <= winLeft - WW'(1);
    end
  end

  // guarded and direct control fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      perSel <= '0;
      enBit  <= 1'b0;
      intEn  <= 1'b0;
    end else begin
      if (ctrlWr) intEn <= regWrData[BIT_IRQ];
      if (commitWr) begin
        perSel <= regWrData[SEL_W-1:0];
        if (!lockMode) enBit <= regWrData[BIT_EN];
      end
    end
  end

  // time-out outputs and reset flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstReq <= 1'b0;
      irq    <= 1'b0;
      flag   <= 1'b0;
    end else begin
      rstReq <= expire && !intEn;
      irq    <= expire && intEn;
      if (expire && !intEn) begin
        flag <= 1'b1;
      end else if (statWr && !regWrData[BIT_FLAG]) begin
        flag <= 1'b0;
      end
    end
  end

  assign strobe.run     = enEff;
  assign strobe.restart = kick;
  assign strobe.tapSel  = perSel;

  assign ctrlRdData = {1'b0, intEn, winOpen, enEff, perSel};
  assign statRdData = {{(DATA_W-1){1'b0}}, flag};
endmodule

// File: rtl/wdog_timed_lock.sv
module wdog_timed_lock
  import wdog_pkg::*;
#(
  parameter int MIN_EXP  = 11,
  parameter int NUM_TAPS = 10,
  parameter int WIN_CYC  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lockMode,
  input  logic        regWrEn,
  input  logic        regSel,
  input  logic [7:0]  regWrData,
  input  logic        kick,
  output logic [7:0]  ctrlRdData,
  output logic [7:0]  statRdData,
  output logic        rstReq,
  output logic        irq
);
  wdStrobe_t strobe;
  logic      expire;

  wdog_ctrl #(.WIN_CYC(WIN_CYC)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lockMode   (lockMode),
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .regWrData  (regWrData),
    .kick       (kick),
    .expire     (expire),
    .strobe     (strobe),
    .ctrlRdData (ctrlRdData),
    .statRdData (statRdData),
    .rstReq     (rstReq),
    .irq        (irq)
  );

  wdog_count #(.MIN_EXP(MIN_EXP), .NUM_TAPS(NUM_TAPS)) u_count (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .expire (expire)
  );
endmodule

// File: rtl/wdog_timed_lock_chk.sv
module wdog_timed_lock_chk #(
  parameter int WIN_CYC = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       lockMode,
  input logic       regWrEn,
  input logic       regSel,
  input logic [7:0] regWrData,
  input logic [7:0] ctrlRdData,
  input logic [7:0] statRdData,
  input logic       rstReq,
  input logic       irq
);
  logic [7:0] winCnt;
  logic       ctrlCommit;
  logic       unusedChk;

  assign ctrlCommit = regWrEn && !regSel && !regWrData[5] && ctrlRdData[5];
  assign unusedChk  = ^{regWrData, ctrlRdData[7:6], statRdData[7:1]};

  // cycles since the most recent opening write while the window reads open
  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (regWrEn && !regSel && regWrData[5] && regWrData[4]) begin
      winCnt <= 8'd1;
    end else if (ctrlRdData[5]) begin
      winCnt <= winCnt + 8'd1;
    end else begin
      winCnt <= '0;
    end
  end

  p_lock_en_r2: assert property (@(posedge clk) disable iff (!rstN)
    lockMode |-> ctrlRdData[4]);

  p_period_guard_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlRdData[3:0]) |-> $past(ctrlCommit));

  p_commit_closes_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrlCommit |=> !ctrlRdData[5]);

  p_window_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdData[5] |-> (winCnt <= 8'(WIN_CYC)));

  p_reset_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  p_flag_with_reset_r8: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> statRdData[0]);

  p_flag_forces_en_r11: assert property (@(posedge clk) disable iff (!rstN)
    statRdData[0] |-> ctrlRdData[4]);

  p_irq_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  p_one_event_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(rstReq && irq));
endmodule

bind wdog_timed_lock wdog_timed_lock_chk #(.WIN_CYC(WIN_CYC)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .lockMode   (lockMode),
  .regWrEn    (regWrEn),
  .regSel     (regSel),
  .regWrData  (regWrData),
  .ctrlRdData (ctrlRdData),
  .statRdData (statRdData),
  .rstReq     (rstReq),
  .irq        (irq)
);

// File: tb/sim_wdog_timed_lock.sv
module sim_wdog_timed_lock;
  localparam int MIN_EXP  = 4;
  localparam int NUM_TAPS = 4;
  localparam int WIN_CYC  = 4;
  localparam int MAX_CYC  = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lockMode = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regSel = 1'b0;
  logic       kick = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] ctrlRdData, statRdData;
  logic       rstReq, irq;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  typedef enum {SIG_CTRL, SIG_STAT, SIG_RST, SIG_IRQ} sig_e;
  typedef struct {
    int         due;
    sig_e       sig;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb[$];

  wdog_timed_lock #(.MIN_EXP(MIN_EXP), .NUM_TAPS(NUM_TAPS), .WIN_CYC(WIN_CYC)) u0 (
    .clk(clk), .rstN(rstN), .lockMode(lockMode), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .kick(kick), .ctrlRdData(ctrlRdData),
    .statRdData(statRdData), .rstReq(rstReq), .irq(irq)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares queued items when due, between clock edges
  always @(negedge clk) begin
    logic [7:0] act;
    #1;
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due <= cyc) begin
        case (sb[i].sig)
          SIG_CTRL: act = ctrlRdData;
          SIG_STAT: act = statRdData;
          SIG_RST:  act = {7'b0, rstReq};
          default:  act = {7'b0, irq};
        endcase
        nChecks++;
        if (act !== sb[i].exp || sb[i].due != cyc) begin
          nFails++;
          $display("FAIL %s: %s at cycle %0d actual %h expected %h",
                   sb[i].req, sb[i].sig.name(), cyc, act, sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > MAX_CYC && !done) begin
      nFails++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, MAX_CYC);
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic expectAt(int due, sig_e s, logic [7:0] e, string r);
    item_t it;
    it.due = due; it.sig = s; it.exp = e; it.req = r;
    sb.push_back(it);
  endtask

  task automatic expectNow(sig_e s, logic [7:0] e, string r);
    expectAt(cyc, s, e, r);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // one write, taken on the next edge; returns at the negedge after it
  task automatic wr(logic sel, logic [7:0] data);
    regSel = sel; regWrData = data; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // returns with cyc equal to the edge that sampled kick
  task automatic doKick();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  // reset pulse due len cycles after the kick edge at cycle e
  task automatic tripAt(int e, int len, string r);
    expectAt(e + len - 1, SIG_RST, 8'h00, r);
    expectAt(e + len,     SIG_RST, 8'h01, r);
    expectAt(e + len + 1, SIG_RST, 8'h00, r);
    expectAt(e + len,     SIG_STAT, 8'h01, r);
  endtask

  task automatic applyReset(logic lock);
    rstN = 1'b0; lockMode = lock;
    idle(3);
    rstN = 1'b1;
  endtask

  initial begin
    int e;
    @(negedge clk);
    applyReset(1'b0);
    expectNow(SIG_CTRL, 8'h00, "R1");
    expectNow(SIG_STAT, 8'h00, "R1");
    expectNow(SIG_RST,  8'h00, "R1");
    expectNow(SIG_IRQ,  8'h00, "R1");

    // direct write cannot change period or enable
    wr(1'b0, 8'h13);
    expectNow(SIG_CTRL, 8'h00, "R3");
    // change-enable without enable opens nothing
    wr(1'b0, 8'h20);
    expectNow(SIG_CTRL, 8'h00, "R4");
    // window opens, then lapses after four edges
    wr(1'b0, 8'h30);
    expectNow(SIG_CTRL, 8'h20, "R4");
    idle(3);
    expectNow(SIG_CTRL, 8'h20, "R6");
    idle(1);
    expectNow(SIG_CTRL, 8'h00, "R6");
    wr(1'b0, 8'h11);
    expectNow(SIG_CTRL, 8'h00, "R6");
    // disabled: no time-out
    idle(40);
    expectNow(SIG_RST, 8'h00, "R13");

    // commit at the last edge of the window
    wr(1'b0, 8'h30);
    idle(3);
    wr(1'b0, 8'h11);
    expectNow(SIG_CTRL, 8'h11, "R5");
    doKick();
    e = cyc;
    tripAt(e, 32, "R8");
    idle(33);

    // flag handling and forced enable
    wr(1'b1, 8'h01);
    expectNow(SIG_STAT, 8'h01, "R11");
    wr(1'b0, 8'h30);
    wr(1'b0, 8'h00);
    expectNow(SIG_CTRL, 8'h10, "R11");
    wr(1'b1, 8'h00);
    expectNow(SIG_STAT, 8'h00, "R11");
    expectNow(SIG_CTRL, 8'h00, "R11");

    // kick restarts the count
    wr(1'b0, 8'h30);
    wr(1'b0, 8'h10);
    expectNow(SIG_CTRL, 8'h10, "R5");
    doKick();
    e = cyc;
    idle(10);
    doKick();
    expectAt(e + 16, SIG_RST, 8'h00, "R9");
    tripAt(cyc, 16, "R9");
    idle(17);

    // reserved code selects the longest tap
    wr(1'b0, 8'h30);
    wr(1'b0, 8'h17);
    expectNow(SIG_CTRL, 8'h17, "R10");
    doKick();
    expectAt(cyc + 64, SIG_RST, 8'h00, "R10");
    tripAt(cyc, 128, "R10");
    idle(129);

    // interrupt mode
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h40);
    expectNow(SIG_CTRL, 8'h57, "R12");
    wr(1'b0, 8'h70);
    wr(1'b0, 8'h50);
    expectNow(SIG_CTRL, 8'h50, "R12");
    doKick();
    expectAt(cyc + 15, SIG_IRQ, 8'h00, "R12");
    expectAt(cyc + 16, SIG_IRQ, 8'h01, "R12");
    expectAt(cyc + 17, SIG_IRQ, 8'h00, "R12");
    expectAt(cyc + 16, SIG_RST, 8'h00, "R12");
    expectAt(cyc + 16, SIG_STAT, 8'h00, "R12");
    idle(17);

    // turn off through the sequence
    wr(1'b0, 8'h30);
    wr(1'b0, 8'h00);
    expectNow(SIG_CTRL, 8'h00, "R13");
    doKick();
    expectAt(cyc + 16, SIG_RST, 8'h00, "R13");
    expectAt(cyc + 16, SIG_IRQ, 8'h00, "R13");
    expectAt(cyc + 32, SIG_RST, 8'h00, "R13");
    idle(40);

    // locked safety mode
    applyReset(1'b1);
    expectNow(SIG_CTRL, 8'h10, "R2");
    expectNow(SIG_STAT, 8'h00, "R2");
    wr(1'b0, 8'h02);
    expectNow(SIG_CTRL, 8'h10, "R3");
    wr(1'b0, 8'h30);
    expectNow(SIG_CTRL, 8'h30, "R4");
    wr(1'b0, 8'h02);
    expectNow(SIG_CTRL, 8'h12, "R7");
    doKick();
    tripAt(cyc, 64, "R8");
    idle(65);
    wr(1'b1, 8'h00);
    expectNow(SIG_CTRL, 8'h12, "R2");

    idle(3);
    while (sb.size() != 0) @(negedge clk);
    idle(1);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule